// File: doc/BRIEF.md
# ALU Status Flag Generator

This block forms the arithmetic status bits of a 16-bit flags word from one ALU result. Each cycle that `valid_i` is high, it takes the operation class, both operands, the carry input, the result and the operand size. One clock later it presents a new flags word. The status bits the class affects are recomputed. Every other bit is copied from the caller's stored flags word `flags_in_i`. The ALU datapath lies outside the block and supplies the result.

Operand size selects where the most significant bit sits: bit 7, bit 15 or bit 31. Bits of the operands and the result above the active size are ignored. For shifts and rotates, the datapath presents the last bit shifted out on `carry_i`. For add and subtract, `carry_i` is the carry-in or borrow-in. For the logical class, `carry_i` is ignored.

Top module: `flag_gen`

## Requirements
- R1: Encodings are op_i 00 add, 01 subtract/compare, 10 logical, 11 shift/rotate, and size_i 00 byte, 01 16-bit, 10 32-bit, with 11 treated as 32-bit. Reset sets flags_o to 16'h0002. A word sampled with valid_i high appears on flags_o after the next rising edge. With valid_i low, flags_o holds.
- R2: Carry is flags_o bit 0. For add it is the carry out of a + b + carry_i at the top bit of the active size.
- R3: For subtract, bit 0 is the borrow out of a - b - carry_i at the active size. Bit 6 (zero) is set when the result is zero, so equal operands with no borrow-in set zero.
- R4: For shift/rotate, bit 0 takes carry_i. Bit 4 and bit 11 keep their values from flags_in_i.
- R5: Sign is flags_o bit 7. It copies the result bit at the top of the active size, for every class.
- R6: Zero is flags_o bit 6. It is set exactly when the result masked to the active size is all zeros, for every class.
- R7: Auxiliary carry is flags_o bit 4. For add and subtract, it is set on a carry or borrow out of result bit 3 into bit 4.
- R8: Parity is flags_o bit 2. It is set when result bits 7:0 hold an even number of ones, whatever the size.
- R9: Overflow is flags_o bit 11. For add and subtract, it is set on signed overflow at the active size, and cleared otherwise.
- R10: The logical class clears bits 0 and 11 and keeps bit 4 from flags_in_i.
- R11: Bits 3, 5 and 8-10, 12-15 copy flags_in_i. Bit 1 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load a new flags word |
| op_i | input | 2 | Operation class |
| size_i | input | 2 | Operand size |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry/borrow in, or last bit shifted out |
| result_i | input | 32 | ALU result |
| flags_in_i | input | 16 | Stored flags word |
| flags_o | output | 16 | Updated flags word |

## Verification
Random operands with random upper garbage are run for every class and size. This shows whether carry, sign and zero are taken at the selected size rather than at bit 31. Directed cases cover several distinctions. Carry out of the top bit, with and without a carry-in, tells carry apart from overflow. Equal-operand compares and borrow at zero separate zero from borrow. A nibble-boundary carry isolates the auxiliary carry. A 16-bit result with a zero low byte shows that parity reads only the low byte. Logical and shift operations with flags_in_i all ones show which bits are cleared and which are kept. A held cycle with changing inputs shows that flags_o holds.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_LOGIC = 2'b10, OP_SHIFT = 2'b11} op_class_e;
  typedef enum logic [1:0] {SZ_8 = 2'b00, SZ_16 = 2'b01, SZ_32 = 2'b10, SZ_WIDE = 2'b11} op_size_e;
  localparam int FLAGS_W   = 16;
  localparam int CF_POS    = 0;
  localparam int ONE_POS   = 1;
  localparam int PF_POS    = 2;
  localparam int AF_POS    = 4;
  localparam int ZF_POS    = 6;
  localparam int SF_POS    = 7;
  localparam int OF_POS    = 11;
  localparam logic [FLAGS_W-1:0] FLAGS_RST = 16'h0002;
endpackage

// File: rtl/flag_size_dec.sv
module flag_size_dec
  import flag_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_size_e          size_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] msb_o
);
  localparam int W8  = (DATA_W < 8)  ? DATA_W : 8;
  localparam int W16 = (DATA_W < 16) ? DATA_W : 16;
  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};
  localparam logic [DATA_W:0] M8  = (ONE << W8) - ONE;
  localparam logic [DATA_W:0] M16 = (ONE << W16) - ONE;

  always_comb begin
    unique case (size_i)
      SZ_8:    begin mask_o = M8[DATA_W-1:0];  msb_o = ONE[DATA_W-1:0] << (W8 - 1);     end
      SZ_16:   begin mask_o = M16[DATA_W-1:0]; msb_o = ONE[DATA_W-1:0] << (W16 - 1);    end
      default: begin mask_o = '1;              msb_o = ONE[DATA_W-1:0] << (DATA_W - 1); end
    endcase
  end
endmodule

// File: rtl/flag_arith.sv
module flag_arith
  import flag_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] msb_i,
  output logic              cf_o,
  output logic              af_o,
  output logic              of_o
);
  logic [DATA_W:0] a_ext, b_ext, full;
  logic            sa, sb, sr;

  assign a_ext = {1'b0, a_i & mask_i};
  assign b_ext = {1'b0, b_i & mask_i};
  // a borrow sign-extends past the size boundary, so one tap serves both
  assign full  = sub_i ? (a_ext - b_ext - {{DATA_W{1'b0}}, cin_i})
                       : (a_ext + b_ext + {{DATA_W{1'b0}}, cin_i});
  assign cf_o  = |(full[DATA_W:1] & msb_i);
  assign af_o  = a_i[4] ^ b_i[4] ^ res_i[4];
  assign sa    = |(a_i & msb_i);
  assign sb    = |(b_i & msb_i);
  assign sr    = |(res_i & msb_i);
  assign of_o  = ((sa ^ sb) == sub_i) && (sr != sa);
endmodule

// File: rtl/flag_result.sv
module flag_result #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] msb_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  assign zf_o = ~|(res_i & mask_i);
  assign sf_o = |(res_i & msb_i);
  assign pf_o = ~^res_i[7:0];
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import flag_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          op_i,
  input  logic [1:0]          size_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                carry_i,
  input  logic [DATA_W-1:0]   result_i,
  input  logic [FLAGS_W-1:0]  flags_in_i,
  output logic [FLAGS_W-1:0]  flags_o
);
  op_class_e          op;
  logic [DATA_W-1:0]  mask, msb;
  logic               ar_cf, ar_af, ar_of, zf, sf, pf;
  logic [FLAGS_W-1:0] nxt, flags_q;

  assign op = op_class_e'(op_i);

  flag_size_dec #(.DATA_W(DATA_W)) u_dec (
    .size_i (op_size_e'(size_i)), .mask_o(mask), .msb_o(msb));

  flag_arith #(.DATA_W(DATA_W)) u_arith (
    .sub_i(op == OP_SUB), .a_i(a_i), .b_i(b_i), .cin_i(carry_i), .res_i(result_i),
    .mask_i(mask), .msb_i(msb), .cf_o(ar_cf), .af_o(ar_af), .of_o(ar_of));

  flag_result #(.DATA_W(DATA_W)) u_res (
    .res_i(result_i), .mask_i(mask), .msb_i(msb), .zf_o(zf), .sf_o(sf), .pf_o(pf));

  always_comb begin
    nxt          = flags_in_i;
    nxt[ONE_POS] = 1'b1;
    nxt[ZF_POS]  = zf;
    nxt[SF_POS]  = sf;
    nxt[PF_POS]  = pf;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nxt[CF_POS] = ar_cf;
        nxt[AF_POS] = ar_af;
        nxt[OF_POS] = ar_of;
      end
      OP_LOGIC: begin
        nxt[CF_POS] = 1'b0;
        nxt[OF_POS] = 1'b0;
      end
      default: nxt[CF_POS] = carry_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= FLAGS_RST;
    else if (valid_i) flags_q <= nxt;
  end

  assign flags_o = flags_q;

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));
  a_r11_bit1_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ONE_POS]);
  a_r11_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[15:12] == $past(flags_in_i[15:12]));
  a_r8_low_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[PF_POS] == ~^$past(result_i[7:0]));
  a_r10_logic_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b10 |=> !flags_o[CF_POS] && !flags_o[OF_POS]);
  a_r4_shift_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b11 |=> flags_o[CF_POS] == $past(carry_i)
      && flags_o[OF_POS] == $past(flags_in_i[OF_POS]));
endmodule

// File: tb/flag_gen_test.sv
module flag_gen_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        valid = 0;
  logic [1:0]  op = 0, size = 0;
  logic [31:0] a = 0, b = 0, res = 0;
  logic        cin = 0;
  logic [15:0] fin = 0;
  logic [15:0] flags;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_gen uut (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .carry_i(cin), .result_i(res), .flags_in_i(fin), .flags_o(flags));

  function automatic int width_of(logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  function automatic logic [31:0] trim(logic [31:0] v, int w);
    logic [31:0] r = 0;
    for (int i = 0; i < w; i++) r[i] = v[i];
    return r;
  endfunction

  // expected word from the requirements
  function automatic logic [15:0] model(logic [1:0] o, logic [1:0] s, logic [31:0] x,
                                        logic [31:0] y, logic c, logic [31:0] r, logic [15:0] f);
    int w = width_of(s);
    logic [15:0] e = f;
    longint unsigned xa = trim(x, w), ya = trim(y, w), lim = 64'd1 << w;
    longint signed sx, sy, sr;
    int ones = 0;
    sx = x[w-1] ? longint'(xa) - longint'(lim) : longint'(xa);
    sy = y[w-1] ? longint'(ya) - longint'(lim) : longint'(ya);
    for (int i = 0; i < 8; i++) ones += r[i];
    e[1] = 1; e[2] = (ones % 2 == 0); e[6] = (trim(r, w) == 0); e[7] = r[w-1];
    case (o)
      2'b00: begin
        e[0] = (xa + ya + c) >= lim;
        e[4] = (x[3:0] + y[3:0] + c) > 15;
        sr = sx + sy + c;
        e[11] = sr >= longint'(lim / 2) || sr < -longint'(lim / 2);
      end
      2'b01: begin
        e[0] = xa < ya + c;
        e[4] = x[3:0] < y[3:0] + c;
        sr = sx - sy - c;
        e[11] = sr >= longint'(lim / 2) || sr < -longint'(lim / 2);
      end
      2'b10: begin e[0] = 0; e[11] = 0; end
      default: e[0] = c;
    endcase
    return e;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one operation; the word shows one edge later
  task automatic apply(logic [1:0] o, logic [1:0] s, logic [31:0] x, logic [31:0] y,
                       logic c, logic [31:0] r, logic [15:0] f, string tag);
    logic [15:0] e;
    op = o; size = s; a = x; b = y; cin = c; res = r; fin = f; valid = 1;
    e = model(o, s, x, y, c, r, f);
    @(negedge clk);
    chk(tag, flags, e);
  endtask

  function automatic logic [31:0] alu(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic c,
                                      int sel);
    case (o)
      2'b00: return x + y + c;
      2'b01: return x - y - c;
      2'b10: return sel[0] ? (x & y) : (x ^ y);
      default: return {x[30:0], c};
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset", flags, 16'h0002);
    rst_ni = 1;
    @(negedge clk);

    // R2 byte carry out at bit 7, not overflow
    apply(2'b00, 2'b00, 32'hAB_FF, 32'h01, 0, 32'h00, 16'h0000, "R2 byte carry");
    // R9 signed overflow 16-bit
    apply(2'b00, 2'b01, 32'h7FFF, 32'h0001, 0, 32'h8000, 16'h0000, "R9 add overflow");
    // R2 carry-in reaches bit 32
    apply(2'b00, 2'b10, 32'hFFFF_FFFF, 32'h0, 1, 32'h0, 16'h0000, "R2 carry-in wrap");
    // R3 compare equal
    apply(2'b01, 2'b10, 32'h1234_5678, 32'h1234_5678, 0, 32'h0, 16'h0000, "R3 compare equal");
    // R3 borrow at zero
    apply(2'b01, 2'b00, 32'h00, 32'h01, 0, 32'hFF, 16'h0000, "R3 borrow");
    // R7 nibble carry only
    apply(2'b00, 2'b00, 32'h0F, 32'h01, 0, 32'h10, 16'h0000, "R7 nibble carry");
    // R8 parity of low byte only
    apply(2'b00, 2'b01, 32'h0100, 32'h0000, 0, 32'h0100, 16'h0000, "R8 parity low byte");
    // R5 R6 sign at size top, garbage above
    apply(2'b10, 2'b00, 32'hFFFF_FF80, 32'hFFFF_FF80, 0, 32'hFFFF_FF80, 16'h0000, "R5 byte sign");
    apply(2'b10, 2'b01, 32'h0, 32'h0, 0, 32'hABCD_0000, 16'h0000, "R6 masked zero");
    // R10 logical clears CF OF, keeps AF
    apply(2'b10, 2'b10, 32'h1, 32'h1, 1, 32'h1, 16'hFFFF, "R10 logic keep AF");
    // R4 shift carry, AF OF kept
    apply(2'b11, 2'b10, 32'h8000_0000, 32'h1, 1, 32'h1, 16'hFFFF, "R4 shift carry");
    apply(2'b11, 2'b00, 32'h0, 32'h1, 0, 32'h2, 16'h0810, "R4 shift keep");
    // R11 passthrough with bit 1 cleared in input
    apply(2'b00, 2'b00, 32'h1, 32'h1, 0, 32'h2, 16'hF72D, "R11 passthrough");

    // R1 hold
    held = flags;
    valid = 0; a = 32'hDEAD; res = 32'h0; op = 2'b10; fin = 16'h0;
    @(negedge clk); @(negedge clk);
    chk("R1 hold", flags, held);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] o = 2'($urandom_range(0, 3));
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [31:0] x = $urandom, y = $urandom;
      logic c = 1'($urandom);
      logic [15:0] f = 16'($urandom);
      if (i % 4 == 0) y = x;
      apply(o, s, x, y, c, alu(o, x, y, c, i), f,
            o == 2'b00 ? "R2 R5 R6 R7 R8 R9 add" : o == 2'b01 ? "R3 R5 R6 R7 R8 R9 sub" :
            o == 2'b10 ? "R10 R5 R6 R8 R11 logic" : "R4 R5 R6 R8 R11 shift");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule